// File: doc/BRIEF.md
# Banked Register File with Sized Writes

This block is the architectural register store for a 32-bit CISC-style datapath. It holds two classes of general registers, data and address, with eight registers in each class and 32 bits per register. A register is named by a class bit and a 3-bit index. Every register access also carries an operand size of byte, word or long. A byte or word operand sits in the low-order bits of the register. A plain sized write merges into the register and leaves the bits above the operand untouched. A sign-extending write instead fills the upper bits with the operand's top bit.

The last address register is the stack pointer. It has two physical copies, one for supervisor mode and one for user mode. The `sup_mode` input picks which copy any access to address index 7 uses, on both the read ports and the write port. The file has two combinational read ports and one write port that writes on the rising clock edge. Read port A also drives the low 24 bits of its register out as an external address.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every physical register to zero. This includes both stack pointer copies.
- R2: A write with size 2'b10 (long) or 2'b11 (also long) replaces all 32 bits with `wr_data`.
- R3: A write with size 2'b00 (byte) and `wr_sext`=0 replaces bits [7:0] and keeps bits [31:8]. A write with size 2'b01 (word) and `wr_sext`=0 replaces bits [15:0] and keeps bits [31:16].
- R4: With `wr_sext`=1, a byte write copies `wr_data[7]` into bits [31:8], and a word write copies `wr_data[15]` into bits [31:16].
- R5: Class 1 (address) with index 7 selects the supervisor stack pointer when `sup_mode`=1 and the user stack pointer when `sup_mode`=0. A write to one copy leaves the other copy unchanged.
- R6: Class 0 (data) and class 1 (address) registers with the same index are separate storage.
- R7: A read port returns `{24'b0, reg[7:0]}` for size 2'b00, `{16'b0, reg[15:0]}` for size 2'b01, and the whole register for size 2'b10 or 2'b11.
- R8: `ra_addr` always equals bits [23:0] of the register that port A selects, whatever `ra_size` is.
- R9: A read of a register during the cycle in which it is being written returns the old value. The new value shows only after the clock edge.
- R10: While `wr_en`=0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_mode | input | 1 | 1 = supervisor copy of address register 7 |
| wr_en | input | 1 | Write enable |
| wr_cls | input | 1 | Write class, 0 = data, 1 = address |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write size code |
| wr_sext | input | 1 | Sign-extend a byte or word write |
| wr_data | input | 32 | Write operand, in the low bits for byte and word |
| ra_cls | input | 1 | Port A class |
| ra_idx | input | 3 | Port A index |
| ra_size | input | 2 | Port A size code |
| ra_data | output | 32 | Port A data, zero-extended to 32 bits |
| ra_addr | output | 24 | Low 24 bits of the register port A selects |
| rb_cls | input | 1 | Port B class |
| rb_idx | input | 3 | Port B index |
| rb_size | input | 2 | Port B size code |
| rb_data | output | 32 | Port B data, zero-extended to 32 bits |

## Verification
Two things are hard to reach through the ports. The first is keeping the two stack pointer copies apart: the same class and index must land in different storage purely because of `sup_mode`. The bench writes distinct values to address index 7 in each mode, then reads index 7 back in both modes. The second is the same-cycle read: the bench holds a write and a read on the same register and samples port A both before and after the clock edge that commits the write.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_LONG  = 2'b10,
    SZ_LONG2 = 2'b11
  } rf_size_e;

  localparam logic CLS_DATA = 1'b0;
  localparam logic CLS_ADDR = 1'b1;
endpackage

// File: rtl/rf_phys_map.sv
module rf_phys_map #(
  parameter int NREG = 8,
  parameter int IW   = $clog2(NREG),
  parameter int PW   = $clog2(2 * NREG + 1)
) (
  input  logic          cls,
  input  logic [IW-1:0] idx,
  input  logic          sup,
  output logic [PW-1:0] phys
);
  localparam int USP = 2 * NREG - 1;
  localparam int SSP = 2 * NREG;

  always_comb begin
    if (cls == rf_pkg::CLS_DATA)
      phys = PW'(idx);
    else if (idx == IW'(NREG - 1))
      phys = sup ? PW'(SSP) : PW'(USP);
    else
      phys = PW'(NREG) + PW'(idx);
  end
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] din,
  input  logic [1:0]    size,
  input  logic          sext,
  output logic [DW-1:0] merged
);
  import rf_pkg::*;

  always_comb begin
    unique case (rf_size_e'(size))
      SZ_BYTE: merged = sext ? {{(DW-8){din[7]}}, din[7:0]}
                             : {old_val[DW-1:8], din[7:0]};
      SZ_WORD: merged = sext ? {{(DW-16){din[15]}}, din[15:0]}
                             : {old_val[DW-1:16], din[15:0]};
      default: merged = din;
    endcase
  end
endmodule

// File: rtl/rf_read_fmt.sv
module rf_read_fmt #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] raw,
  input  logic [1:0]    size,
  output logic [DW-1:0] dout
);
  import rf_pkg::*;

  always_comb begin
    unique case (rf_size_e'(size))
      SZ_BYTE: dout = {{(DW-8){1'b0}}, raw[7:0]};
      SZ_WORD: dout = {{(DW-16){1'b0}}, raw[15:0]};
      default: dout = raw;
    endcase
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DW    = 32,
  parameter int NPHYS = 17,
  parameter int PW    = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          w_en,
  input  logic [PW-1:0] w_idx,
  input  logic [DW-1:0] w_val,
  output logic [DW-1:0] w_old,
  input  logic [PW-1:0] a_idx,
  output logic [DW-1:0] a_val,
  input  logic [PW-1:0] b_idx,
  output logic [DW-1:0] b_val
);
  localparam int SSP = NPHYS - 1;
  localparam int USP = NPHYS - 2;

  logic [DW-1:0] regs [NPHYS];

  for (genvar g = 0; g < NPHYS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (w_en && w_idx == PW'(g))
        regs[g] <= w_val;
    end
  end

  assign w_old = regs[w_idx];
  assign a_val = regs[a_idx];
  assign b_val = regs[b_idx];

  // R1: the cycle after reset, both stack pointers and a data register are zero
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs[SSP] == '0 && regs[USP] == '0 && regs[0] == '0));

  // R5: a write aimed elsewhere leaves each stack pointer copy alone
  assert_ssp_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (w_idx != PW'(SSP) || !w_en) |=> $stable(regs[SSP]));
  assert_usp_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (w_idx != PW'(USP) || !w_en) |=> $stable(regs[USP]));

  // R10: nothing changes while write is disabled
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !w_en |=> ($stable(regs[0]) && $stable(regs[SSP])));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW    = 32,
  parameter int NREG  = 8,
  parameter int EXT_W = 24,
  parameter int IW    = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sup_mode,
  input  logic             wr_en,
  input  logic             wr_cls,
  input  logic [IW-1:0]    wr_idx,
  input  logic [1:0]       wr_size,
  input  logic             wr_sext,
  input  logic [DW-1:0]    wr_data,
  input  logic             ra_cls,
  input  logic [IW-1:0]    ra_idx,
  input  logic [1:0]       ra_size,
  output logic [DW-1:0]    ra_data,
  output logic [EXT_W-1:0] ra_addr,
  input  logic             rb_cls,
  input  logic [IW-1:0]    rb_idx,
  input  logic [1:0]       rb_size,
  output logic [DW-1:0]    rb_data
);
  localparam int NPHYS = 2 * NREG + 1;
  localparam int PW    = $clog2(NPHYS);

  logic [PW-1:0] w_phys, a_phys, b_phys;
  logic [DW-1:0] w_old, w_val, a_raw, b_raw;

  rf_phys_map #(.NREG(NREG), .IW(IW), .PW(PW)) u_map_w (
    .cls(wr_cls), .idx(wr_idx), .sup(sup_mode), .phys(w_phys));
  rf_phys_map #(.NREG(NREG), .IW(IW), .PW(PW)) u_map_a (
    .cls(ra_cls), .idx(ra_idx), .sup(sup_mode), .phys(a_phys));
  rf_phys_map #(.NREG(NREG), .IW(IW), .PW(PW)) u_map_b (
    .cls(rb_cls), .idx(rb_idx), .sup(sup_mode), .phys(b_phys));

  rf_write_merge #(.DW(DW)) u_merge (
    .old_val(w_old), .din(wr_data), .size(wr_size), .sext(wr_sext),
    .merged(w_val));

  rf_storage #(.DW(DW), .NPHYS(NPHYS), .PW(PW)) u_store (
    .clk(clk), .rst(rst), .w_en(wr_en), .w_idx(w_phys), .w_val(w_val),
    .w_old(w_old), .a_idx(a_phys), .a_val(a_raw), .b_idx(b_phys),
    .b_val(b_raw));

  rf_read_fmt #(.DW(DW)) u_fmt_a (.raw(a_raw), .size(ra_size), .dout(ra_data));
  rf_read_fmt #(.DW(DW)) u_fmt_b (.raw(b_raw), .size(rb_size), .dout(rb_data));

  assign ra_addr = a_raw[EXT_W-1:0];

  // R2: long sizes pass the operand through whole
  assert_long_full_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size[1]) |-> (w_val == wr_data));

  // R3: plain narrow writes keep the stored upper bits
  assert_keep_byte_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b00 && !wr_sext) |-> (w_val[DW-1:8] == w_old[DW-1:8]));
  assert_keep_word_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b01 && !wr_sext) |-> (w_val[DW-1:16] == w_old[DW-1:16]));

  // R4: sign-extending writes fill the upper bits from the operand's top bit
  assert_sext_byte_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b00 && wr_sext) |-> (w_val[DW-1:8] == {(DW-8){wr_data[7]}}));
  assert_sext_word_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b01 && wr_sext) |-> (w_val[DW-1:16] == {(DW-16){wr_data[15]}}));

  // R8: the external address follows port A's long value
  assert_ext_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (ra_size[1]) |-> (ra_addr == ra_data[EXT_W-1:0]));
endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  localparam int CLK_P = 10;
  localparam int NVEC  = 8;

  // {cls, idx[2:0], size[1:0], sext, data[31:0], expected long readback[31:0]}
  localparam logic [70:0] VEC [NVEC] = '{
    {1'b0, 3'd2, 2'd2, 1'b0, 32'h12345678, 32'h12345678},  // R2
    {1'b0, 3'd2, 2'd0, 1'b0, 32'hFFFFFFAB, 32'h123456AB},  // R3
    {1'b0, 3'd2, 2'd1, 1'b0, 32'h0000CDEF, 32'h1234CDEF},  // R3
    {1'b0, 3'd2, 2'd0, 1'b1, 32'h00000080, 32'hFFFFFF80},  // R4
    {1'b0, 3'd2, 2'd1, 1'b1, 32'h00007FFF, 32'h00007FFF},  // R4
    {1'b0, 3'd2, 2'd3, 1'b0, 32'h89ABCDEF, 32'h89ABCDEF},  // R2
    {1'b1, 3'd2, 2'd1, 1'b1, 32'h00008000, 32'hFFFF8000},  // R4
    {1'b1, 3'd2, 2'd0, 1'b0, 32'hFFFFFF11, 32'hFFFF8011}   // R3
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup_mode = 1'b1;
  logic wr_en = 1'b0, wr_cls = 1'b0, wr_sext = 1'b0;
  logic [2:0] wr_idx = '0, ra_idx = '0, rb_idx = '0;
  logic [1:0] wr_size = '0, ra_size = 2'd2, rb_size = 2'd2;
  logic [31:0] wr_data = '0;
  logic ra_cls = 1'b0, rb_cls = 1'b0;
  logic [31:0] ra_data, rb_data;
  logic [23:0] ra_addr;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst), .sup_mode(sup_mode),
    .wr_en(wr_en), .wr_cls(wr_cls), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_sext(wr_sext), .wr_data(wr_data),
    .ra_cls(ra_cls), .ra_idx(ra_idx), .ra_size(ra_size),
    .ra_data(ra_data), .ra_addr(ra_addr),
    .rb_cls(rb_cls), .rb_idx(rb_idx), .rb_size(rb_size), .rb_data(rb_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic cls, input logic [2:0] idx, input logic [1:0] sz,
                          input logic sx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_cls = cls; wr_idx = idx; wr_size = sz; wr_sext = sx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_a(input logic cls, input logic [2:0] idx, input logic [1:0] sz);
    ra_cls = cls; ra_idx = idx; ra_size = sz;
    #1;
  endtask

  task automatic set_b(input logic cls, input logic [2:0] idx, input logic [1:0] sz);
    rb_cls = cls; rb_idx = idx; rb_size = sz;
    #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    sup_mode = 1'b1;
    set_a(1'b0, 3'd0, 2'd2); check("R1 D0", ra_data, 32'h0);
    set_a(1'b1, 3'd0, 2'd2); check("R1 A0", ra_data, 32'h0);
    set_a(1'b1, 3'd7, 2'd2); check("R1 SSP", ra_data, 32'h0);
    sup_mode = 1'b0;
    set_a(1'b1, 3'd7, 2'd2); check("R1 USP", ra_data, 32'h0);
    sup_mode = 1'b1;

    // vector table: write, then read the register back as long
    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i][70], VEC[i][69:67], VEC[i][66:65], VEC[i][64], VEC[i][63:32]);
      set_a(VEC[i][70], VEC[i][69:67], 2'd2);
      check("R2/R3/R4 vector", ra_data, VEC[i][31:0]);
    end

    // R5: banked stack pointer
    sup_mode = 1'b1; do_write(1'b1, 3'd7, 2'd2, 1'b0, 32'h00AA0000);
    sup_mode = 1'b0; do_write(1'b1, 3'd7, 2'd2, 1'b0, 32'h00BB0000);
    sup_mode = 1'b1; set_a(1'b1, 3'd7, 2'd2); check("R5 SSP", ra_data, 32'h00AA0000);
    // R8: external address from the supervisor stack pointer
    check("R8 addr SSP", {8'h0, ra_addr}, 32'h00AA0000);
    sup_mode = 1'b0; set_a(1'b1, 3'd7, 2'd2); check("R5 USP", ra_data, 32'h00BB0000);
    sup_mode = 1'b1;

    // R6: data and address registers with the same index are separate
    do_write(1'b0, 3'd5, 2'd2, 1'b0, 32'h11111111);
    do_write(1'b1, 3'd5, 2'd2, 1'b0, 32'h22222222);
    set_b(1'b0, 3'd5, 2'd2); check("R6 D5", rb_data, 32'h11111111);
    set_b(1'b1, 3'd5, 2'd2); check("R6 A5", rb_data, 32'h22222222);

    // R7: sized reads on port B (D2 holds 89ABCDEF)
    set_b(1'b0, 3'd2, 2'd0); check("R7 byte", rb_data, 32'h000000EF);
    set_b(1'b0, 3'd2, 2'd1); check("R7 word", rb_data, 32'h0000CDEF);
    set_b(1'b0, 3'd2, 2'd3); check("R7 long alt", rb_data, 32'h89ABCDEF);

    // R8: address with a narrow read size
    do_write(1'b1, 3'd3, 2'd2, 1'b0, 32'hFF123456);
    set_a(1'b1, 3'd3, 2'd0); check("R8 addr byte size", {8'h0, ra_addr}, 32'h00123456);

    // R9: old value during the write cycle, new value after the edge
    set_a(1'b0, 3'd2, 2'd2);
    @(negedge clk);
    wr_en = 1'b1; wr_cls = 1'b0; wr_idx = 3'd2; wr_size = 2'd2; wr_sext = 1'b0;
    wr_data = 32'h0BADF00D;
    #1 check("R9 before edge", ra_data, 32'h89ABCDEF);
    @(posedge clk); #1 check("R9 after edge", ra_data, 32'h0BADF00D);
    @(negedge clk); wr_en = 1'b0;

    // R10: write enable low, data and address driven, nothing changes
    wr_cls = 1'b0; wr_idx = 3'd2; wr_size = 2'd2; wr_data = 32'hDEADBEEF;
    repeat (2) @(negedge clk);
    set_a(1'b0, 3'd2, 2'd2); check("R10 no write", ra_data, 32'h0BADF00D);

    // R1: reset after activity clears both stack pointers
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    set_a(1'b1, 3'd7, 2'd2); check("R1 SSP after reset", ra_data, 32'h0);
    sup_mode = 1'b0;
    set_a(1'b1, 3'd7, 2'd2); check("R1 USP after reset", ra_data, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule